// File: doc/BRIEF.md
# Serial Engine Command Processor

This block reads a packed stream of command bytes from a host-side FIFO. It turns them into activity on a synchronous serial port (clock, data out, data in) and on an 8-bit general-purpose pin bank. A command byte with bit 7 set is a control opcode. Control opcodes set or read the pins, load the clock divisor, select a divide-by-5 prescaler, clock the port with no data, or flush responses. A command byte with bit 7 clear is a data transfer. Its flag bits choose the data direction, the bit order, and byte or bit counting.

The arguments of a command follow it in the stream, low byte first. Payload bytes for a transfer are pulled one at a time and passed to an internal shift engine. Captured bytes and read results go out as single-cycle pushes to a response FIFO. An unrecognised opcode produces a two-byte error reply, and parsing then continues with the next byte. While a shift or idle-clock command runs, the block stalls its input with a ready signal.

Top module: `sse_cmd_proc`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are 0x00, `sclk` is low, `cmd_ready` is high, and no response or flush pulse is produced.
- R2: Opcode 0x80 takes two argument bytes: first the pin value, which goes to `pin_out`, then the direction mask, which goes to `pin_oe` (1 means the pin is an output). No other command changes either register.
- R3: Opcode 0x81 pushes one response byte equal to `pins_lo_in`. Opcode 0x83 pushes one response byte equal to `pins_hi_in`.
- R4: Opcode 0x86 takes a 16-bit divisor D, low byte first. The serial clock period is 2*(D+1)*P system cycles. P is 5 after opcode 0x8B and 1 after opcode 0x8A. After reset D=0 and P=1.
- R5: Opcode 0x8E with one length byte L gives L+1 serial clock pulses. Opcode 0x8F with a 16-bit length L (low byte first) gives (L+1)*8 pulses. `sdo` stays low during both.
- R6: A byte-mode transfer (bit 7=0, bit 1=0) takes a 16-bit length n-1, low byte first, and shifts n bytes. Bit 4 (data out) pulls n payload bytes from the stream. Bit 3 sends each byte LSB first; when it is clear, each byte goes MSB first. `sdo` changes only while `sclk` is low. With bit 4 clear, `sdo` is 0. Bits 0, 2 and 6 have no effect.
- R7: With bit 5 (data in) set, `sdi` is sampled on each rising `sclk`, and each finished byte or bit group is pushed as a response. MSB-first capture shifts in at bit 0. LSB-first capture shifts in at bit 7.
- R8: A bit-mode transfer (bit 1=1) takes one length byte whose bits [2:0] give n-1, so n is 1 to 8. With data out set, one data byte follows and n bits are sent from it: from bit 7 downward (MSB first) or from bit 0 upward (LSB first).
- R9: Opcode 0x87 produces a one-cycle pulse on `rsp_flush`.
- R10: Any other opcode with bit 7 set pushes 0xFA and then the opcode byte on consecutive cycles. The next byte in the stream is then parsed as a new command.
- R11: `cmd_ready` is low whenever the shift engine is running, and `sclk` is low whenever it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_data | input | 8 | Command stream byte from the host FIFO |
| cmd_valid | input | 1 | Command byte is present |
| cmd_ready | output | 1 | Block accepts the command byte this cycle |
| rsp_valid | output | 1 | One-cycle push into the response FIFO |
| rsp_data | output | 8 | Response byte |
| rsp_flush | output | 1 | One-cycle request to send pending responses now |
| pins_lo_in | input | 8 | Levels of the low pin byte |
| pins_hi_in | input | 8 | Levels of the high pin byte |
| pin_out | output | 8 | Driven values of the low pin byte |
| pin_oe | output | 8 | Output enables of the low pin byte |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Transfers are run with several payloads. Multi-byte MSB-first output shows that bytes keep their stream order and bits go high to low. A single-bit LSB-first byte (0x01) separates the two bit orders, because a symmetric byte would pass either way. With `sdi` looped back to `sdo`, both orders and a 3-bit group show that capture fills from the end the requirements name. Input-only transfers with `sdi` held high show that `sdo` stays low. Two divisor/prescaler pairs and two idle-clock lengths check the period formula and the pulse counts, so a one-off error in either shows up.

// File: rtl/sse_pkg.sv
package sse_pkg;

    typedef enum logic [2:0] {
        ST_OP,
        ST_ARG,
        ST_UNIT,
        ST_RUN,
        ST_ERR
    } st_e;

    localparam logic [7:0] OP_PIN_SET  = 8'h80;
    localparam logic [7:0] OP_PIN_RDLO = 8'h81;
    localparam logic [7:0] OP_PIN_RDHI = 8'h83;
    localparam logic [7:0] OP_DIV      = 8'h86;
    localparam logic [7:0] OP_FLUSH    = 8'h87;
    localparam logic [7:0] OP_PRE_OFF  = 8'h8A;
    localparam logic [7:0] OP_PRE_ON   = 8'h8B;
    localparam logic [7:0] OP_IDLE_BIT = 8'h8E;
    localparam logic [7:0] OP_IDLE_BYT = 8'h8F;
    localparam logic [7:0] ERR_MARK    = 8'hFA;

    localparam int F_BITS = 1;
    localparam int F_LSB  = 3;
    localparam int F_OUT  = 4;
    localparam int F_IN   = 5;

    // number of argument bytes that follow an opcode
    function automatic logic [1:0] arg_count(input logic [7:0] op);
        if (!op[7])
            return op[F_BITS] ? 2'd1 : 2'd2;
        case (op)
            OP_PIN_SET, OP_DIV, OP_IDLE_BYT: return 2'd2;
            OP_IDLE_BIT:                     return 2'd1;
            default:                         return 2'd0;
        endcase
    endfunction

    function automatic logic is_known(input logic [7:0] op);
        case (op)
            OP_PIN_SET, OP_PIN_RDLO, OP_PIN_RDHI, OP_DIV, OP_FLUSH,
            OP_PRE_OFF, OP_PRE_ON, OP_IDLE_BIT, OP_IDLE_BYT: return 1'b1;
            default: return !op[7];
        endcase
    endfunction

endpackage

// File: rtl/sse_clkgen.sv
module sse_clkgen #(
    parameter int DIV_W = 16,
    parameter int PRE   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             pre_en,
    output logic             tick
);
    localparam int CW = DIV_W + $clog2(PRE) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] base;
    logic [CW-1:0] limit;

    assign base  = CW'(div) + CW'(1);
    assign limit = pre_en ? (base * CW'(PRE) - CW'(1)) : CW'(div);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= limit);

endmodule

// File: rtl/sse_shifter.sv
module sse_shifter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] npulse,
    input  logic [7:0]       tx,
    input  logic             lsb,
    input  logic             sdi,
    output logic             sclk,
    output logic             sdo,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx
);
    logic [CNT_W-1:0] left;
    logic [7:0]       txsh;
    logic             lsb_q;

    assign sdo = lsb_q ? txsh[0] : txsh[7];

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            busy  <= 1'b0;
            sclk  <= 1'b0;
            left  <= '0;
            txsh  <= '0;
            lsb_q <= 1'b0;
            rx    <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            sclk  <= 1'b0;
            left  <= npulse;
            txsh  <= tx;
            lsb_q <= lsb;
            rx    <= '0;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
                rx   <= lsb_q ? {sdi, rx[7:1]} : {rx[6:0], sdi};
            end else begin
                sclk <= 1'b0;
                txsh <= lsb_q ? {1'b0, txsh[7:1]} : {txsh[6:0], 1'b0};
                left <= left - CNT_W'(1);
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    a_r11_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    a_r6_sdo_on_low_phase: assert property (@(posedge clk) disable iff (rst)
        (busy && sclk && $past(busy)) |-> $stable(sdo));

endmodule

// File: rtl/sse_cmd_proc.sv
module sse_cmd_proc
    import sse_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int PRE   = 5,
    parameter int LEN_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cmd_data,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    output logic       rsp_flush,
    input  logic [7:0] pins_lo_in,
    input  logic [7:0] pins_hi_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe,
    output logic       sclk,
    output logic       sdo,
    input  logic       sdi
);
    localparam int UW = LEN_W + 1;
    localparam int PW = 9;

    st_e              st;
    logic [7:0]       op_q, a0;
    logic [1:0]       argi, nargs;
    logic [DIV_W-1:0] div_q;
    logic             pre_q;
    logic [UW-1:0]    units;
    logic [PW-1:0]    npulse;
    logic             need_pl, push_rx, lsb_q;

    logic       fire, sh_start, sh_busy, sh_done, tick;
    logic [7:0] sh_rx, sh_tx, lo_b, hi_b;

    assign cmd_ready = (st == ST_OP) || (st == ST_ARG) || (st == ST_UNIT && need_pl);
    assign fire      = cmd_valid && cmd_ready;
    assign lo_b      = (argi == 2'd0) ? cmd_data : a0;
    assign hi_b      = cmd_data;
    assign sh_start  = (st == ST_UNIT) && (!need_pl || cmd_valid);
    assign sh_tx     = need_pl ? cmd_data : 8'h00;

    sse_clkgen #(.DIV_W(DIV_W), .PRE(PRE)) u_clk (
        .clk(clk), .rst(rst), .run(sh_busy), .div(div_q), .pre_en(pre_q), .tick(tick)
    );

    sse_shifter #(.CNT_W(PW)) u_sh (
        .clk(clk), .rst(rst), .tick(tick), .start(sh_start), .npulse(npulse),
        .tx(sh_tx), .lsb(lsb_q), .sdi(sdi), .sclk(sclk), .sdo(sdo),
        .busy(sh_busy), .done(sh_done), .rx(sh_rx)
    );

    always_ff @(posedge clk) begin
        rsp_valid <= 1'b0;
        rsp_flush <= 1'b0;
        if (rst) begin
            st      <= ST_OP;
            op_q    <= '0;
            a0      <= '0;
            argi    <= '0;
            nargs   <= '0;
            div_q   <= '0;
            pre_q   <= 1'b0;
            units   <= '0;
            npulse  <= '0;
            need_pl <= 1'b0;
            push_rx <= 1'b0;
            lsb_q   <= 1'b0;
            pin_out <= '0;
            pin_oe  <= '0;
            rsp_data <= '0;
        end else begin
            case (st)
                ST_OP: if (fire) begin
                    op_q  <= cmd_data;
                    argi  <= '0;
                    nargs <= arg_count(cmd_data);
                    if (arg_count(cmd_data) != 2'd0)
                        st <= ST_ARG;
                    else if (!is_known(cmd_data)) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= ERR_MARK;
                        st        <= ST_ERR;
                    end else begin
                        case (cmd_data)
                            OP_PIN_RDLO: begin rsp_valid <= 1'b1; rsp_data <= pins_lo_in; end
                            OP_PIN_RDHI: begin rsp_valid <= 1'b1; rsp_data <= pins_hi_in; end
                            OP_FLUSH:    rsp_flush <= 1'b1;
                            OP_PRE_OFF:  pre_q <= 1'b0;
                            OP_PRE_ON:   pre_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_ARG: if (fire) begin
                    a0   <= cmd_data;
                    argi <= argi + 2'd1;
                    if (argi == nargs - 2'd1) begin
                        st      <= ST_UNIT;
                        need_pl <= 1'b0;
                        push_rx <= 1'b0;
                        lsb_q   <= 1'b0;
                        npulse  <= PW'(8);
                        units   <= {1'b0, hi_b, lo_b} + UW'(1);
                        if (!op_q[7]) begin
                            need_pl <= op_q[F_OUT];
                            push_rx <= op_q[F_IN];
                            lsb_q   <= op_q[F_LSB];
                            if (op_q[F_BITS]) begin
                                units  <= UW'(1);
                                npulse <= PW'(lo_b[2:0]) + PW'(1);
                            end
                        end else begin
                            case (op_q)
                                OP_PIN_SET: begin pin_out <= lo_b; pin_oe <= hi_b; st <= ST_OP; end
                                OP_DIV:     begin div_q <= DIV_W'({hi_b, lo_b}); st <= ST_OP; end
                                OP_IDLE_BIT: begin
                                    units  <= UW'(1);
                                    npulse <= PW'(lo_b) + PW'(1);
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                ST_UNIT: if (sh_start) st <= ST_RUN;
                ST_RUN: if (sh_done) begin
                    if (push_rx) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= sh_rx;
                    end
                    units <= units - UW'(1);
                    st    <= (units == UW'(1)) ? ST_OP : ST_UNIT;
                end
                ST_ERR: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= op_q;
                    st        <= ST_OP;
                end
                default: st <= ST_OP;
            endcase
        end
    end

    a_r11_stall_while_shifting: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !cmd_ready);

    a_r2_pins_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pin_out) && $stable(pin_oe));

    a_r10_err_mark: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OP && fire && !is_known(cmd_data)) |=> rsp_valid && rsp_data == ERR_MARK);

    a_r10_err_echo: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OP && fire && !is_known(cmd_data)) |=> ##1 (rsp_valid && rsp_data == $past(cmd_data, 2)));

endmodule

// File: tb/sse_cmd_proc_test.sv
module sse_cmd_proc_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] cmd_data = '0;
    logic cmd_valid = 1'b0;
    logic cmd_ready, rsp_valid, rsp_flush, sclk, sdo, sdi;
    logic [7:0] rsp_data, pin_out, pin_oe;
    logic [7:0] pins_lo_in = 8'h00;
    logic [7:0] pins_hi_in = 8'h00;
    logic loop_en = 1'b0;
    logic sdi_fix = 1'b0;

    int checks = 0;
    int fails = 0;
    int rises = 0;
    int flushes = 0;
    int rsp_cnt = 0;
    int period = 0;
    time last_rise = 0;
    logic [31:0] sdo_log = '0;
    logic [7:0] rq[$];

    always #5 clk = ~clk;
    assign sdi = loop_en ? sdo : sdi_fix;

    sse_cmd_proc uut (
        .clk(clk), .rst(rst), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_flush(rsp_flush), .pins_lo_in(pins_lo_in), .pins_hi_in(pins_hi_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .sclk(sclk), .sdo(sdo), .sdi(sdi)
    );

    always @(posedge sclk) begin
        rises++;
        period = int'(($time - last_rise) / 10);
        last_rise = $time;
        sdo_log = {sdo_log[30:0], sdo};
    end

    always @(negedge clk) begin
        if (rsp_valid) begin rq.push_back(rsp_data); rsp_cnt++; end
        if (rsp_flush) flushes++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        cmd_data = b;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rsp(input logic [7:0] exp, input string req);
        logic [7:0] got;
        int w = 0;
        while (rq.size() == 0 && w < 2000) begin @(negedge clk); w++; end
        got = (rq.size() != 0) ? rq.pop_front() : 8'hxx;
        check(got === exp, req, {24'b0, got}, {24'b0, exp});
    endtask

    task automatic t_reset;
        check(pin_out == 8'h00 && pin_oe == 8'h00, "R1", {pin_out, pin_oe}, 0);
        check(!sclk && cmd_ready, "R1", {sclk, cmd_ready}, 1);
        check(rsp_cnt == 0 && flushes == 0, "R1", rsp_cnt + flushes, 0);
    endtask

    task automatic t_pins;
        send(8'h80); send(8'hA5); send(8'h0F);
        settle(2);
        check(pin_out == 8'hA5 && pin_oe == 8'h0F, "R2", {pin_out, pin_oe}, 16'hA50F);
        pins_lo_in = 8'h3C; pins_hi_in = 8'hC3;
        send(8'h81); expect_rsp(8'h3C, "R3 low");
        send(8'h83); expect_rsp(8'hC3, "R3 high");
        check(pin_out == 8'hA5 && pin_oe == 8'h0F, "R2 hold", {pin_out, pin_oe}, 16'hA50F);
    endtask

    task automatic t_flush_err;
        int f0 = flushes;
        send(8'h87); settle(2);
        check(flushes == f0 + 1, "R9", flushes, f0 + 1);
        send(8'h99);
        expect_rsp(8'hFA, "R10 mark");
        expect_rsp(8'h99, "R10 echo");
        send(8'h81); expect_rsp(8'h3C, "R10 resume");
    endtask

    task automatic t_clock;
        send(8'h86); send(8'h02); send(8'h00);
        rises = 0;
        send(8'h8E); send(8'h03); settle(100);
        check(rises == 4, "R5 bit pulses", rises, 4);
        check(period == 6, "R4 div2", period, 6);
        send(8'h8B);
        send(8'h8E); send(8'h02); settle(200);
        check(period == 30, "R4 prescale", period, 30);
        send(8'h8A); send(8'h86); send(8'h00); send(8'h00);
        rises = 0; sdo_log = '0;
        send(8'h8F); send(8'h01); send(8'h00);
        settle(3);
        check(!cmd_ready, "R11 stall", cmd_ready, 0);
        settle(80);
        check(rises == 16, "R5 byte pulses", rises, 16);
        check(sdo_log[15:0] == 16'h0, "R5 sdo low", sdo_log, 0);
        check(cmd_ready && !sclk, "R11 idle", {cmd_ready, sclk}, 2);
    endtask

    task automatic t_xfer;
        int r0;
        sdo_log = '0;
        send(8'h11); send(8'h01); send(8'h00); send(8'hA5); send(8'h3C); settle(30);
        check(sdo_log[15:0] == 16'hA53C, "R6 msb out", sdo_log, 32'hA53C);
        r0 = rsp_cnt;
        send(8'h18); send(8'h00); send(8'h00); send(8'h01); settle(30);
        check(sdo_log[7:0] == 8'h80, "R6 lsb out", sdo_log[7:0], 8'h80);
        check(rsp_cnt == r0, "R6 no in", rsp_cnt, r0);
        loop_en = 1'b1;
        send(8'h35); send(8'h00); send(8'h00); send(8'h5A); expect_rsp(8'h5A, "R7 msb loop");
        send(8'h38); send(8'h00); send(8'h00); send(8'h01); expect_rsp(8'h01, "R7 lsb loop");
        send(8'h32); send(8'h02); send(8'hA0); expect_rsp(8'h05, "R8 msb bits");
        check(sdo_log[2:0] == 3'b101, "R8 bits out", sdo_log[2:0], 3'b101);
        send(8'h3A); send(8'h02); send(8'h05); expect_rsp(8'hA0, "R8 lsb bits");
        loop_en = 1'b0; sdi_fix = 1'b1; sdo_log = '1;
        send(8'h20); send(8'h00); send(8'h00); expect_rsp(8'hFF, "R7 in only");
        check(sdo_log[7:0] == 8'h00, "R6 sdo zero", sdo_log[7:0], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(2);
        t_reset();
        t_pins();
        t_flush_err();
        t_clock();
        t_xfer();
        settle(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule